// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers five external interrupt request pins and turns them into one request towards a processor core. It gives that request an 8-bit interrupt type. Each pin has its own small control register. The register selects whether the pin is sensed as an active-high level or as a rising edge, whether the pin is blocked, and a 3-bit priority in which smaller numbers are more urgent.

Every pin first passes through a two-stage synchronizer. In edge mode, a detected rising edge sets a pending flag that remains set until the core acknowledges that source. In level mode, nothing is stored: the synchronized pin itself is the request. Among the unblocked requests, a combinational arbiter chooses the one with the smallest priority value. When two requests share a priority, the lower pin number wins.

The type of the chosen source appears on the type output in the same cycle as the request line. A one-cycle acknowledge pulse clears the stored edge request of the source that is being presented at that moment. The control registers are accessed through a simple write strobe, an address and a combinational read-data bus.

Top module: `extint_ctrl`

## Requirements
- R1: The register for source i sits at address i, for i from 0 to 4. Bit 4 selects level mode (1) or rising-edge mode (0). Bit 3 blocks the source when it is 1. Bits 2:0 hold the priority. Bits 15:5 always read 0, and writes to them are ignored. Addresses 5 to 7 read as 0, and writes to them have no effect.
- R2: After reset, every control register reads 000Fh (edge mode, blocked, priority 7), and the request line and type output are both 0.
- R3: In level mode, a source requests exactly while its synchronized pin is high. The request appears at the second rising clock edge after the pin rises, and it disappears two edges after the pin falls. It is never stored.
- R4: In edge mode, a rising edge sets a pending flag that is visible as a request at the third clock edge after the pin rises. The flag stays set after the pin falls, until the source is acknowledged.
- R5: A blocked source raises no request. An edge that arrives while the source is blocked is still stored, and it raises the request as soon as the source is unblocked.
- R6: Among the active requests, the smallest priority value wins.
- R7: When active requests share the smallest priority value, the lowest-numbered source wins.
- R8: Sources 0 to 4 present types 0Ch, 0Dh, 0Eh, 0Fh and 10h. When there is no request, the type output is 00h.
- R9: An acknowledge clears the stored edge request of the source presented in that cycle, at that clock edge. Other stored requests are kept. A level-mode source that is still high keeps requesting.
- R10: The request line is high in exactly those cycles in which at least one unblocked source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pin | input | 5 | External interrupt request pins, asynchronous |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 3 | Control register address (source index) |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Read data of the addressed control register |
| int_ack | input | 1 | One-cycle acknowledge of the presented request |
| int_req | output | 1 | Interrupt request to the core |
| int_type | output | 8 | Interrupt type of the winning source |

## Verification
The delays differ by result, so each is checked at its own cycle:
- A level request appears two rising edges after the pin changes, and an edge request three edges after.
- Register writes and acknowledges take effect at the single edge that follows the strobe.
- Read data is combinational on the address.

The bench drives every input just after a falling edge. It queues each expectation at the exact falling edge where the count of rising edges says the result is due, and the monitor compares a quarter period later. Checks before the due edge confirm that an edge-mode request is not visible early.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int PRIO_W = 3;
    localparam int CFG_W  = PRIO_W + 2;

    // register layout: [4] level mode, [3] block, [2:0] priority
    typedef struct packed {
        logic              lvl;
        logic              msk;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{lvl: 1'b0, msk: 1'b1, prio: '1};
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/extint_cfg.sv
module extint_cfg
    import extint_pkg::*;
#(
    parameter int N      = 5,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output src_cfg_t [N-1:0]      cfg_o
);
    typedef struct packed {
        src_cfg_t [N-1:0] regs;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (we && addr == ADDR_W'(i))
                st_d.regs[i] = src_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{regs: {N{CFG_RESET}}};
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(i))
                rdata[CFG_W-1:0] = st_q.regs[i];
        end
    end

    assign cfg_o = st_q.regs;
endmodule

// File: rtl/extint_pend.sv
module extint_pend #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] lvl_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a fresh edge wins over a clear in the same cycle
        st_d.pend = ((st_q.pend & ~clr) | rise) & ~lvl_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/extint_arb.sv
module extint_arb
    import extint_pkg::*;
#(
    parameter int         N         = 5,
    parameter logic [7:0] BASE_TYPE = 8'h0C
) (
    input  logic [N-1:0]             active,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     req,
    output logic [7:0]               typ,
    output logic [N-1:0]             win
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        found = 1'b0;
        best  = '1;
        idx   = '0;
        // strict compare keeps the lower index on equal priority
        for (int i = 0; i < N; i++) begin
            if (active[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                idx   = IDX_W'(i);
            end
        end
        req = found;
        win = found ? (N'(1) << idx) : '0;
        typ = found ? (BASE_TYPE + 8'(idx)) : 8'h00;
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int         NUM_SRC   = 5,
    parameter int         ADDR_W    = 3,
    parameter int         DATA_W    = 16,
    parameter logic [7:0] BASE_TYPE = 8'h0C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] int_pin,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               int_ack,
    output logic               int_req,
    output logic [7:0]         int_type
);
    src_cfg_t [NUM_SRC-1:0]             cfg;
    logic [NUM_SRC-1:0]                 sync_lvl, sync_rise;
    logic [NUM_SRC-1:0]                 lvl_vec, mask_vec, pend_vec;
    logic [NUM_SRC-1:0]                 active, win, clr;
    logic [NUM_SRC-1:0][PRIO_W-1:0]     prio_vec;

    extint_sync #(.N(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(int_pin),
        .lvl_o(sync_lvl), .rise_o(sync_rise)
    );

    extint_cfg #(.N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg_o(cfg)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign lvl_vec[g]  = cfg[g].lvl;
        assign mask_vec[g] = cfg[g].msk;
        assign prio_vec[g] = cfg[g].prio;
        assign active[g]   = !cfg[g].msk &&
                             (cfg[g].lvl ? sync_lvl[g] : pend_vec[g]);
    end

    assign clr = int_ack ? win : '0;

    extint_pend #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise(sync_rise),
        .lvl_mode(lvl_vec), .clr(clr), .pend_o(pend_vec)
    );

    extint_arb #(.N(NUM_SRC), .BASE_TYPE(BASE_TYPE)) u_arb (
        .active(active), .prio(prio_vec),
        .req(int_req), .typ(int_type), .win(win)
    );
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
    parameter int         N         = 5,
    parameter int         ADDR_W    = 3,
    parameter int         DATA_W    = 16,
    parameter logic [7:0] BASE_TYPE = 8'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              int_ack,
    input logic              int_req,
    input logic [7:0]        int_type,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      mask
);
    // R1: a write to a valid address reads back its low five bits, upper bits zero
    p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr < ADDR_W'(N)) |=>
        (reg_addr != $past(reg_addr) ||
         reg_rdata == {{(DATA_W-5){1'b0}}, $past(reg_wdata[4:0])}));

    // R5: with every source blocked there is no request
    p_all_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !int_req);

    // R8: idle type is zero
    p_idle_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> int_type == 8'h00);

    // R8: presented type lies in the type range of the sources
    p_type_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_type >= BASE_TYPE && int_type < BASE_TYPE + 8'(N)));

    // R4: a stored edge request only drops after an acknowledge or a register write
    for (genvar i = 0; i < N; i++) begin : g_pend
        p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> ($past(int_ack) || $past(reg_we)));
    end
endmodule

bind extint_ctrl extint_ctrl_chk #(
    .N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_TYPE(BASE_TYPE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_ack(int_ack),
    .int_req(int_req), .int_type(int_type), .pend(pend_vec), .mask(mask_vec)
);

// File: tb/extint_ctrl_test.sv
`timescale 1ns/1ps
module extint_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  int_pin = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        int_ack = 1'b0;
    logic        int_req;
    logic [7:0]  int_type;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    extint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_ack(int_ack), .int_req(int_req), .int_type(int_type)
    );

    // monitor: compares queued expectations a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                act = it.kind ? reg_rdata : {7'b0, int_req, int_type};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk_irq(input logic req, input logic [7:0] typ, input string tag);
        sb.push_back('{kind: 1'b0, exp: {7'b0, req, typ}, tag: tag});
        @(negedge clk);
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        reg_addr = a;
        sb.push_back('{kind: 1'b1, exp: e, tag: tag});
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_ack();
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic pulse(input int i);
        int_pin[i] = 1'b1;
        @(negedge clk);
        int_pin[i] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk_irq(1'b0, 8'h00, "R2 idle after reset");
        for (int a = 0; a < 5; a++) chk_rd(3'(a), 16'h000F, "R2 reset value");
        chk_rd(3'd7, 16'h0000, "R1 unused address reads 0");

        wr(3'd0, 16'hFFE2);
        chk_rd(3'd0, 16'h0002, "R1 reserved bits ignored");
        wr(3'd6, 16'h001F);
        chk_rd(3'd6, 16'h0000, "R1 write to unused address");
        chk_rd(3'd0, 16'h0002, "R1 unused write left source 0");

        // R4 edge mode timing and hold
        int_pin[0] = 1'b1;
        chk_irq(1'b0, 8'h00, "R4 not yet");
        chk_irq(1'b0, 8'h00, "R4 not yet");
        chk_irq(1'b0, 8'h00, "R4 not yet");
        chk_irq(1'b1, 8'h0C, "R4 edge request due");
        int_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_irq(1'b1, 8'h0C, "R4 held after pin low");
        do_ack();
        chk_irq(1'b0, 8'h00, "R9 ack clears edge request");

        // R3 level mode
        wr(3'd1, 16'h0011);
        int_pin[1] = 1'b1;
        chk_irq(1'b0, 8'h00, "R3 not yet");
        chk_irq(1'b0, 8'h00, "R3 not yet");
        chk_irq(1'b1, 8'h0D, "R3 level request due");
        int_pin[1] = 1'b0;
        chk_irq(1'b1, 8'h0D, "R3 still high in sync");
        chk_irq(1'b1, 8'h0D, "R3 still high in sync");
        chk_irq(1'b0, 8'h00, "R3 level not stored");

        // R5 blocked edge stored
        pulse(2);
        repeat (3) @(negedge clk);
        chk_irq(1'b0, 8'h00, "R5 blocked source silent");
        wr(3'd2, 16'h0007);
        chk_irq(1'b1, 8'h0E, "R5 stored edge after unblock");

        // R6 priority
        wr(3'd3, 16'h0003);
        pulse(3);
        repeat (3) @(negedge clk);
        chk_irq(1'b1, 8'h0F, "R6 smaller priority wins");
        do_ack();
        chk_irq(1'b1, 8'h0E, "R9 other stored request kept");
        do_ack();
        chk_irq(1'b0, 8'h00, "R9 last request cleared");

        // R7 tie, R8 type of source 4, R9 level unaffected by ack
        wr(3'd4, 16'h0013);
        int_pin[4] = 1'b1;
        pulse(3);
        repeat (3) @(negedge clk);
        chk_irq(1'b1, 8'h0F, "R7 tie lower index wins");
        do_ack();
        chk_irq(1'b1, 8'h10, "R8 source 4 type");
        do_ack();
        chk_irq(1'b1, 8'h10, "R9 level source keeps requesting");

        // R10 request with several active, blocking a level source
        int_pin[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk_irq(1'b1, 8'h0D, "R10 two active, priority 1 wins");
        wr(3'd1, 16'h0019);
        chk_irq(1'b1, 8'h10, "R5 blocked level source skipped");
        chk_rd(3'd1, 16'h0019, "R1 readback");
        int_pin[1] = 1'b0;
        int_pin[4] = 1'b0;
        repeat (3) @(negedge clk);
        chk_irq(1'b0, 8'h00, "R10 no active source");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule